// File: doc/BRIEF.md
# Serial Channel Pair Command and Status Unit

This block holds the control state of two serial channels that share one interrupt-status byte. A host drives a byte-wide register bus. On each channel it can program two mode registers, issue commands, send characters for transmission and pull received characters out of a small queue. It can also read each channel's status byte and the shared interrupt-status byte. Characters come in on a byte-stream port for each channel. The same port carries a strobe that reports a line break. Bit timing, shifting and error detection are done elsewhere: this unit sees only whole characters and break events.

A command write does two things in one access. Its low four bits turn the receiver and transmitter on or off. Its high four bits select one operation: reset the mode pointer, reset the receiver, reset the transmitter, clear the error flags or clear the break interrupts. Each channel queues at most three received characters. A break sets a sticky flag, places a zero character in the queue, and raises the break interrupt again on each read of the holding register for as long as the flag stays set. Written characters go out as a one-cycle strobe on the transmit port, and only while the transmitter is ready.

Top module: `upair_block`

## Requirements
- R1: After a synchronous active-low reset, all status bits, interrupt bits, `rx_ready` and `tx_valid` are 0, both mode registers read 0, and the mode pointer selects the first mode register.
- R2: In a control write (`bus_reg`=1), bit 0 turns the receiver on and bit 1 turns it off. When both bits are set the receiver ends up off.
- R3: Control bit 2 sets status bit 2 (TXRDY), status bit 3 (TXEMT) and the channel's TX interrupt bit. Control bit 3, or operation code 3 in bits 7:4, clears all three. A clear wins over a set in the same write.
- R4: The mode registers share `bus_reg`=0 through a pointer. The pointer starts at the first register, moves to the second after any read or write there, and stays on the second until operation code 1.
- R5: A character is accepted only while the receiver is on (after the same cycle's bus access) and fewer than 3 characters are queued. Other characters are dropped. `rx_ready` is 1 exactly when the receiver is on and the queue is not full.
- R6: Status bit 0 (RXRDY) shows a non-empty queue and status bit 1 (FFULL) shows a full queue. A character that enters an empty queue sets the channel's RX interrupt bit.
- R7: A holding-register read (`bus_reg`=2) returns the entry at the read index. The index then advances modulo 3, even when the queue is empty. A non-zero count drops by one. When the count reaches zero, the RX interrupt bit clears.
- R8: Operation code 2 turns the receiver off, empties the queue and clears the RX interrupt bit.
- R9: Operation code 4 clears status bits 7 to 4. Operation code 5 clears the break interrupt bits of both channels. Codes 0 and 6 to 15 change nothing.
- R10: A break strobe sets status bit 7. If that bit was clear, the strobe also sets the channel's BRK interrupt bit. It enqueues 0x00 under the R5 rules, and any `rx_data` in that cycle is ignored.
- R11: A holding-register read while status bit 7 is set sets the channel's BRK interrupt bit.
- R12: A holding-register write is forwarded as a one-cycle `tx_valid` with the byte on the next cycle, but only while TXRDY is set. Otherwise the write is ignored.
- R13: The interrupt byte puts channel c's TX, RX and BRK bits at positions 4c, 4c+1 and 4c+2. Bits 3 and 7 read 0. `bus_reg`=3 reads this byte.
- R14: Within one cycle, the bus access takes effect before that cycle's stream events. A character or break that arrives in the same cycle as the read that empties the queue leaves RXRDY and the RX interrupt set. A break in the same cycle as a break-interrupt clear leaves the BRK bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when bus_wr is set) |
| bus_chan | input | 1 | Channel select |
| bus_reg | input | 2 | Register select: 0 mode, 1 status/control, 2 holding, 3 interrupt byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| rx_valid | input | 2 | Per-channel received-character strobe |
| rx_data | input | 16 | Per-channel received character, channel c at bits 8c+7:8c |
| rx_break | input | 2 | Per-channel break event strobe |
| rx_ready | output | 2 | Per-channel receiver on and queue not full |
| tx_valid | output | 2 | Per-channel transmit character strobe |
| tx_data | output | 16 | Per-channel transmit character |
| chan_status | output | 16 | Status byte of channel c at bits 8c+7:8c |
| int_status | output | 8 | Shared interrupt-status byte |

## Verification
The bench builds the block with its defaults: a queue depth of 3 and 8-bit characters. With a depth of three, index wrap-around, full-queue rejection and reads past empty each take only a few characters, so every one of them occurs many times in a short run. Directed sequences cover the command combinations, the break re-report path and the same-cycle orderings. A long mixed run then drives both channels at once against a behavioural model.

// File: rtl/upair_pkg.sv
package upair_pkg;
    // register selects on the host bus
    localparam logic [1:0] RS_MODE = 2'd0;
    localparam logic [1:0] RS_CTRL = 2'd1;
    localparam logic [1:0] RS_HOLD = 2'd2;
    localparam logic [1:0] RS_INTS = 2'd3;

    // operation codes carried in control bits 7:4
    localparam logic [3:0] OP_MPTR   = 4'd1;
    localparam logic [3:0] OP_RXRST  = 4'd2;
    localparam logic [3:0] OP_TXRST  = 4'd3;
    localparam logic [3:0] OP_ERRCLR = 4'd4;
    localparam logic [3:0] OP_BRKCLR = 4'd5;

    // control low-nibble bit positions
    localparam int CB_RX_ON  = 0;
    localparam int CB_RX_OFF = 1;
    localparam int CB_TX_ON  = 2;
    localparam int CB_TX_OFF = 3;

    localparam int STAT_W = 8;
    localparam int INTS_PER_CH = 4;

    // per-channel interrupt bits, packed so bit 0 = tx, 1 = rx, 2 = brk
    typedef struct packed {
        logic brk;
        logic rx;
        logic tx;
    } chan_ints_t;
endpackage

// File: rtl/upair_rx_queue.sv
// Receive queue of one channel.
// Circular store with read index and pending count. Within a cycle a pop
// is applied first, then a flush, then a push, which lands behind the
// entries that remain. Assumes DEPTH >= 2 and that the caller gates push
// with the receiver enable.
module upair_rx_queue #(
    parameter int DEPTH = 3,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         pop,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic [DW-1:0]                head,
    output logic                         first,
    output logic                         drained
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int SW = ((IW > CW) ? IW : CW) + 1;

    logic [DW-1:0] store [DEPTH];
    logic [IW-1:0] ridx, ridx_p, wpos;
    logic [CW-1:0] cnt_p;
    logic [SW-1:0] sum;
    logic          push_ok;

    // index and count after this cycle's pop and flush
    always_comb begin
        ridx_p = ridx;
        if (pop) ridx_p = (ridx == IW'(DEPTH - 1)) ? '0 : ridx + 1'b1;
        cnt_p = cnt;
        if (pop && cnt != '0) cnt_p = cnt - 1'b1;
        if (flush) cnt_p = '0;
    end

    // write slot behind the surviving entries, with wrap
    always_comb begin
        sum     = SW'(ridx_p) + SW'(cnt_p);
        wpos    = (sum >= SW'(DEPTH)) ? IW'(sum - SW'(DEPTH)) : IW'(sum);
        push_ok = push && (cnt_p < CW'(DEPTH));
    end

    assign head    = store[ridx];
    assign first   = push_ok && (cnt_p == '0);
    assign drained = pop && !flush && (cnt == CW'(1));

    // index and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ridx <= '0;
            cnt  <= '0;
        end else begin
            ridx <= ridx_p;
            cnt  <= cnt_p + CW'(push_ok);
        end
    end

    // character storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (push_ok) begin
            store[wpos] <= push_data;
        end
    end
endmodule

// File: rtl/upair_chan.sv
// Command and status logic of one channel.
// Decodes control writes (enable bits first, then the operation code),
// keeps the mode registers, transmit and break flags and the channel's
// interrupt bits, and feeds its receive queue. Assumes wr and rd are
// already qualified by the channel select and never both set.
module upair_chan
    import upair_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        rsel,
    input  logic [DW-1:0]     wdata,
    input  logic              brk_int_clr,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              rx_break,
    output logic [DW-1:0]     rd_mode,
    output logic [STAT_W-1:0] status,
    output logic [DW-1:0]     head,
    output chan_ints_t        ints,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_data,
    output logic              brk_clr_req
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mode_r [2];
    logic          mptr;
    logic          rx_en, rx_en_n;
    logic          txrdy, txemt, brk;
    logic          cmd_wr, hold_rd, hold_wr, mode_acc;
    logic [3:0]    op;
    logic          tx_set, tx_clr, brk_keep;
    logic [CW-1:0] cnt;
    logic          q_first, q_drained;

    assign cmd_wr   = wr && (rsel == RS_CTRL);
    assign hold_rd  = rd && (rsel == RS_HOLD);
    assign hold_wr  = wr && (rsel == RS_HOLD);
    assign mode_acc = (wr || rd) && (rsel == RS_MODE);
    assign op       = wdata[7:4];
    assign tx_set   = cmd_wr && wdata[CB_TX_ON];
    assign tx_clr   = cmd_wr && (wdata[CB_TX_OFF] || op == OP_TXRST);
    assign brk_keep = brk && !(cmd_wr && op == OP_ERRCLR);
    assign brk_clr_req = cmd_wr && (op == OP_BRKCLR);

    // receiver enable after this cycle's control write
    always_comb begin
        rx_en_n = rx_en;
        if (cmd_wr && wdata[CB_RX_ON])  rx_en_n = 1'b1;
        if (cmd_wr && wdata[CB_RX_OFF]) rx_en_n = 1'b0;
        if (cmd_wr && op == OP_RXRST)   rx_en_n = 1'b0;
    end

    upair_rx_queue #(.DEPTH(DEPTH), .DW(DW)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd_wr && op == OP_RXRST),
        .pop       (hold_rd),
        .push      (rx_en_n && (rx_valid || rx_break)),
        .push_data (rx_break ? '0 : rx_data),
        .cnt       (cnt),
        .head      (head),
        .first     (q_first),
        .drained   (q_drained)
    );

    // receiver enable register
    always_ff @(posedge clk) begin
        if (!rst_n) rx_en <= 1'b0;
        else        rx_en <= rx_en_n;
    end

    // mode registers and their shared pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r[0] <= '0;
            mode_r[1] <= '0;
            mptr      <= 1'b0;
        end else begin
            if (wr && rsel == RS_MODE) mode_r[mptr] <= wdata;
            if (cmd_wr && op == OP_MPTR) mptr <= 1'b0;
            else if (mode_acc)           mptr <= 1'b1;
        end
    end

    // transmitter ready, empty and interrupt flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txrdy  <= 1'b0;
            txemt  <= 1'b0;
            ints.tx <= 1'b0;
        end else if (tx_clr) begin
            txrdy  <= 1'b0;
            txemt  <= 1'b0;
            ints.tx <= 1'b0;
        end else if (tx_set) begin
            txrdy  <= 1'b1;
            txemt  <= 1'b1;
            ints.tx <= 1'b1;
        end
    end

    // sticky break status: error clear, then a new break sets it
    always_ff @(posedge clk) begin
        if (!rst_n)        brk <= 1'b0;
        else if (rx_break) brk <= 1'b1;
        else               brk <= brk_keep;
    end

    // break interrupt: block clear first, then the read and break sets
    always_ff @(posedge clk) begin
        if (!rst_n)                      ints.brk <= 1'b0;
        else if (rx_break && !brk_keep)  ints.brk <= 1'b1;
        else if (hold_rd && brk)         ints.brk <= 1'b1;
        else if (brk_int_clr)            ints.brk <= 1'b0;
    end

    // receive interrupt: set on first entry, cleared on drain or flush
    always_ff @(posedge clk) begin
        if (!rst_n)                                    ints.rx <= 1'b0;
        else if (q_first)                              ints.rx <= 1'b1;
        else if (q_drained || (cmd_wr && op == OP_RXRST)) ints.rx <= 1'b0;
    end

    // transmit strobe, forwarded only while ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= hold_wr && txrdy;
            if (hold_wr && txrdy) tx_data <= wdata;
        end
    end

    assign rd_mode  = mode_r[mptr];
    assign rx_ready = rx_en && (cnt < CW'(DEPTH));
    assign status   = {brk, 3'b000, txemt, txrdy, cnt == CW'(DEPTH), cnt != '0};
endmodule

// File: rtl/upair_block.sv
// Two serial channels sharing one interrupt-status byte.
// Routes the host bus to the selected channel, merges the channel
// interrupt bits into the shared byte, shares the break-interrupt clear
// and builds the combinational read data. Assumes DW >= 8.
module upair_block
    import upair_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_chan,
    input  logic [1:0]        bus_reg,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [1:0]        rx_valid,
    input  logic [2*DW-1:0]   rx_data,
    input  logic [1:0]        rx_break,
    output logic [1:0]        rx_ready,
    output logic [1:0]        tx_valid,
    output logic [2*DW-1:0]   tx_data,
    output logic [2*STAT_W-1:0] chan_status,
    output logic [2*INTS_PER_CH-1:0] int_status
);
    localparam int NCH = 2;

    logic [DW-1:0]     mode_v [NCH];
    logic [STAT_W-1:0] stat_v [NCH];
    logic [DW-1:0]     head_v [NCH];
    chan_ints_t        ints_v [NCH];
    logic [NCH-1:0]    brk_req;
    logic              brk_int_clr;

    assign brk_int_clr = |brk_req;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_c, rd_c;
        assign wr_c = bus_wr && (bus_chan == 1'(c));
        assign rd_c = bus_rd && !bus_wr && (bus_chan == 1'(c));

        upair_chan #(.DW(DW), .DEPTH(DEPTH)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr          (wr_c),
            .rd          (rd_c),
            .rsel        (bus_reg),
            .wdata       (bus_wdata),
            .brk_int_clr (brk_int_clr),
            .rx_valid    (rx_valid[c]),
            .rx_data     (rx_data[c*DW +: DW]),
            .rx_break    (rx_break[c]),
            .rd_mode     (mode_v[c]),
            .status      (stat_v[c]),
            .head        (head_v[c]),
            .ints        (ints_v[c]),
            .rx_ready    (rx_ready[c]),
            .tx_valid    (tx_valid[c]),
            .tx_data     (tx_data[c*DW +: DW]),
            .brk_clr_req (brk_req[c])
        );

        assign chan_status[c*STAT_W +: STAT_W] = stat_v[c];
        assign int_status[c*INTS_PER_CH +: INTS_PER_CH] = {1'b0, ints_v[c]};
    end

    // read data selected by register and channel
    always_comb begin
        case (bus_reg)
            RS_MODE: bus_rdata = mode_v[bus_chan];
            RS_CTRL: bus_rdata = DW'(stat_v[bus_chan]);
            RS_HOLD: bus_rdata = head_v[bus_chan];
            default: bus_rdata = DW'(int_status);
        endcase
    end
endmodule

// File: rtl/upair_block_chk.sv
// Property checker for upair_block, attached by bind below.
// Relates the status byte, the interrupt byte and the strobes of each
// channel to the bus accesses and stream events that may change them.
module upair_block_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_chan,
    input logic [1:0]  bus_reg,
    input logic [1:0]  rx_break,
    input logic [1:0]  tx_valid,
    input logic [15:0] chan_status,
    input logic [7:0]  int_status
);
    for (genvar c = 0; c < 2; c++) begin : g_chk
        // R3: interrupt TX bit moves with TXRDY
        a_r3_tx_int_follows: assert property (@(posedge clk) disable iff (!rst_n)
            int_status[4*c] == chan_status[8*c+2]);
        // R3: TXEMT moves with TXRDY
        a_r3_txemt_with_txrdy: assert property (@(posedge clk) disable iff (!rst_n)
            chan_status[8*c+3] == chan_status[8*c+2]);
        // R6: RX interrupt bit mirrors a non-empty queue
        a_r6_rx_int_follows: assert property (@(posedge clk) disable iff (!rst_n)
            int_status[4*c+1] == chan_status[8*c]);
        // R6: a full queue is never empty
        a_r6_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
            chan_status[8*c+1] |-> chan_status[8*c]);
        // R7: RXRDY only falls after a holding read or a control write
        a_r7_rxrdy_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(chan_status[8*c]) |-> $past(bus_chan == 1'(c) &&
                ((bus_rd && !bus_wr && bus_reg == 2'd2) || (bus_wr && bus_reg == 2'd1))));
        // R10: a break leaves the break status set
        a_r10_break_latches: assert property (@(posedge clk) disable iff (!rst_n)
            rx_break[c] |=> chan_status[8*c+7]);
        // R12: a transmit strobe needs a holding write while ready
        a_r12_tx_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid[c] |-> $past(bus_wr && bus_chan == 1'(c) && bus_reg == 2'd2
                                  && chan_status[8*c+2]));
    end
    // R13: reserved interrupt positions stay clear after any access
    a_r13_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |=> (int_status[3] == 1'b0 && int_status[7] == 1'b0));
endmodule

bind upair_block upair_block_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_chan    (bus_chan),
    .bus_reg     (bus_reg),
    .rx_break    (rx_break),
    .tx_valid    (tx_valid),
    .chan_status (chan_status),
    .int_status  (int_status)
);

// File: tb/upair_block_tb_top.sv
module upair_block_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk, rst_n;
    logic        bus_wr, bus_rd, bus_chan;
    logic [1:0]  bus_reg;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [1:0]  rx_valid, rx_break, rx_ready, tx_valid;
    logic [15:0] rx_data, tx_data, chan_status;
    logic [7:0]  int_status;

    upair_block dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_chan(bus_chan), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .chan_status(chan_status), .int_status(int_status)
    );

    // behavioural model state
    int m_mr [2][2];
    int m_ptr [2], m_rxen [2], m_txrdy [2], m_brk [2];
    int m_q [2][$];
    int m_store [2][3];
    int m_ridx [2];
    int m_itx [2], m_irx [2], m_ibrk [2];
    int m_txv [2], m_txd [2];

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(int c);
        int n = m_q[c].size();
        return {m_brk[c][0], 3'b000, m_txrdy[c][0], m_txrdy[c][0], n == 3, n != 0};
    endfunction

    function automatic logic [7:0] exp_ints();
        return {1'b0, m_ibrk[1][0], m_irx[1][0], m_itx[1][0],
                1'b0, m_ibrk[0][0], m_irx[0][0], m_itx[0][0]};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_mr[c][0] = 0; m_mr[c][1] = 0; m_ptr[c] = 0; m_rxen[c] = 0;
            m_txrdy[c] = 0; m_brk[c] = 0; m_q[c].delete(); m_ridx[c] = 0;
            for (int k = 0; k < 3; k++) m_store[c][k] = 0;
            m_itx[c] = 0; m_irx[c] = 0; m_ibrk[c] = 0; m_txv[c] = 0; m_txd[c] = 0;
        end
    endtask

    task automatic model_push(int c, int b);
        if (m_rxen[c] != 0 && m_q[c].size() < 3) begin
            m_store[c][(m_ridx[c] + m_q[c].size()) % 3] = b;
            if (m_q[c].size() == 0) m_irx[c] = 1;
            m_q[c].push_back(b);
        end
    endtask

    task automatic model_step(bit wr, bit rd, bit ch, bit [1:0] rg, bit [7:0] wd,
                              bit [1:0] rv, bit [15:0] rdat, bit [1:0] rb);
        int c = ch;
        m_txv[0] = 0; m_txv[1] = 0;
        if (wr) begin
            case (rg)
                2'd0: begin m_mr[c][m_ptr[c]] = wd; m_ptr[c] = 1; end
                2'd1: begin
                    if (wd[0]) m_rxen[c] = 1;
                    if (wd[1]) m_rxen[c] = 0;
                    if (wd[2]) begin m_txrdy[c] = 1; m_itx[c] = 1; end
                    if (wd[3]) begin m_txrdy[c] = 0; m_itx[c] = 0; end
                    case (wd[7:4])
                        4'd1: m_ptr[c] = 0;
                        4'd2: begin m_rxen[c] = 0; m_q[c].delete(); m_irx[c] = 0; end
                        4'd3: begin m_txrdy[c] = 0; m_itx[c] = 0; end
                        4'd4: m_brk[c] = 0;
                        4'd5: begin m_ibrk[0] = 0; m_ibrk[1] = 0; end
                        default: ;
                    endcase
                end
                2'd2: if (m_txrdy[c] != 0) begin m_txv[c] = 1; m_txd[c] = wd; end
                default: ;
            endcase
        end else if (rd) begin
            if (rg == 2'd0) m_ptr[c] = 1;
            if (rg == 2'd2) begin
                m_ridx[c] = (m_ridx[c] + 1) % 3;
                if (m_q[c].size() > 0) begin
                    void'(m_q[c].pop_front());
                    if (m_q[c].size() == 0) m_irx[c] = 0;
                end
                if (m_brk[c] != 0) m_ibrk[c] = 1;
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (rb[k]) begin
                if (m_brk[k] == 0) begin m_brk[k] = 1; m_ibrk[k] = 1; end
                model_push(k, 0);
            end else if (rv[k]) begin
                model_push(k, rdat[8*k +: 8]);
            end
        end
    endtask

    function automatic logic [7:0] exp_rdata(bit ch, bit [1:0] rg);
        case (rg)
            2'd0: return 8'(m_mr[ch][m_ptr[ch]]);
            2'd1: return exp_stat(ch);
            2'd2: return 8'(m_store[ch][m_ridx[ch]]);
            default: return exp_ints();
        endcase
    endfunction

    task automatic check_state(string tag);
        chk(tag, "chan0 status", {24'b0, chan_status[7:0]}, {24'b0, exp_stat(0)});
        chk(tag, "chan1 status", {24'b0, chan_status[15:8]}, {24'b0, exp_stat(1)});
        chk(tag, "int_status", {24'b0, int_status}, {24'b0, exp_ints()});
        for (int c = 0; c < 2; c++) begin
            chk(tag, "rx_ready", {31'b0, rx_ready[c]},
                {31'b0, (m_rxen[c] != 0 && m_q[c].size() < 3)});
            chk(tag, "tx_valid", {31'b0, tx_valid[c]}, {31'b0, m_txv[c] != 0});
            if (m_txv[c] != 0)
                chk(tag, "tx_data", {24'b0, tx_data[8*c +: 8]}, 32'(m_txd[c]));
        end
    endtask

    // one clock: drive after a falling edge, check read data, step, check state
    task automatic cyc(bit wr, bit rd, bit ch, bit [1:0] rg, bit [7:0] wd,
                       bit [1:0] rv, bit [15:0] rdat, bit [1:0] rb, string tag);
        bus_wr = wr; bus_rd = rd; bus_chan = ch; bus_reg = rg; bus_wdata = wd;
        rx_valid = rv; rx_data = rdat; rx_break = rb;
        #1;
        if (rd && !wr) chk(tag, "bus_rdata", {24'b0, bus_rdata}, {24'b0, exp_rdata(ch, rg)});
        @(posedge clk);
        model_step(wr, rd, ch, rg, wd, rv, rdat, rb);
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic wr_reg(bit ch, bit [1:0] rg, bit [7:0] d, string tag);
        cyc(1, 0, ch, rg, d, 2'b00, 16'h0, 2'b00, tag);
    endtask
    task automatic rd_reg(bit ch, bit [1:0] rg, string tag);
        cyc(0, 1, ch, rg, 8'h0, 2'b00, 16'h0, 2'b00, tag);
    endtask
    task automatic push_byte(bit ch, bit [7:0] d, string tag);
        cyc(0, 0, 0, 0, 8'h0, ch ? 2'b10 : 2'b01, ch ? {d, 8'h0} : {8'h0, d}, 2'b00, tag);
    endtask
    task automatic brk_ev(bit ch, string tag);
        cyc(0, 0, 0, 0, 8'h0, 2'b00, 16'h0, ch ? 2'b10 : 2'b01, tag);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual running expected done");
        report();
    end

    initial begin
        model_reset();
        rst_n = 0; bus_wr = 0; bus_rd = 0; bus_chan = 0; bus_reg = 0; bus_wdata = 0;
        rx_valid = 0; rx_data = 0; rx_break = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_state("R1");
        rd_reg(0, 2'd0, "R1");
        rd_reg(1, 2'd2, "R1");
        rd_reg(1, 2'd3, "R1");

        // receiver enable and disable bits
        wr_reg(0, 2'd1, 8'h01, "R2");
        wr_reg(0, 2'd1, 8'h03, "R2");
        wr_reg(0, 2'd1, 8'h01, "R2");

        // transmitter flags
        wr_reg(0, 2'd1, 8'h04, "R3");
        wr_reg(0, 2'd1, 8'h0C, "R3");
        wr_reg(0, 2'd1, 8'h04, "R3");
        wr_reg(0, 2'd1, 8'h30, "R3");
        wr_reg(0, 2'd1, 8'h04, "R3");

        // mode pointer
        wr_reg(0, 2'd0, 8'h11, "R4");
        wr_reg(0, 2'd0, 8'h22, "R4");
        wr_reg(0, 2'd0, 8'h33, "R4");
        rd_reg(0, 2'd0, "R4");
        wr_reg(0, 2'd1, 8'h10, "R4");
        rd_reg(0, 2'd0, "R4");
        rd_reg(0, 2'd0, "R4");

        // acceptance, full queue, arrival interrupt
        push_byte(1, 8'hA0, "R5");
        wr_reg(1, 2'd1, 8'h01, "R5");
        push_byte(1, 8'hA1, "R6");
        push_byte(1, 8'hA2, "R6");
        push_byte(1, 8'hA3, "R6");
        push_byte(1, 8'hA4, "R5");

        // holding reads, wrap and read past empty
        rd_reg(1, 2'd2, "R7");
        rd_reg(1, 2'd2, "R7");
        rd_reg(1, 2'd2, "R7");
        rd_reg(1, 2'd2, "R7");
        push_byte(1, 8'hB1, "R7");
        rd_reg(1, 2'd2, "R7");

        // receiver reset
        push_byte(0, 8'hC1, "R8");
        push_byte(0, 8'hC2, "R8");
        wr_reg(0, 2'd1, 8'h21, "R8");
        push_byte(0, 8'hC3, "R8");
        wr_reg(0, 2'd1, 8'h01, "R8");

        // break event, interrupt clear, repeat and re-report
        brk_ev(0, "R10");
        rd_reg(0, 2'd3, "R13");
        wr_reg(1, 2'd1, 8'h50, "R9");
        brk_ev(0, "R10");
        rd_reg(0, 2'd2, "R11");
        rd_reg(0, 2'd2, "R11");
        cyc(0, 0, 0, 0, 8'h0, 2'b01, 16'h00EE, 2'b01, "R10");
        for (int op = 6; op < 16; op++) wr_reg(0, 2'd1, 8'(op << 4), "R9");
        wr_reg(0, 2'd1, 8'h00, "R9");
        wr_reg(0, 2'd1, 8'h40, "R9");
        wr_reg(0, 2'd1, 8'h50, "R9");

        // transmit forwarding
        wr_reg(0, 2'd2, 8'h5A, "R12");
        wr_reg(1, 2'd2, 8'h6B, "R12");
        idle_cyc("R12");

        // same-cycle ordering
        wr_reg(0, 2'd1, 8'h20, "R14");
        wr_reg(0, 2'd1, 8'h01, "R14");
        push_byte(0, 8'h77, "R14");
        cyc(0, 1, 0, 2'd2, 8'h0, 2'b01, 16'h0088, 2'b00, "R14");
        cyc(1, 0, 1, 2'd1, 8'h50, 2'b00, 16'h0, 2'b01, "R14");
        cyc(1, 0, 0, 2'd1, 8'h40, 2'b00, 16'h0, 2'b01, "R14");
        rd_reg(1, 2'd3, "R13");

        // mixed traffic on both channels
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] r = $urandom;
            bit wr = (r[3:0] < 4);
            bit rd = !wr && (r[3:0] < 10);
            bit [7:0] wd = r[31:24];
            if (wr && r[5:4] == 2'd1 && r[6]) wd[7:4] = 4'(r[9:7]);
            cyc(wr, rd, r[10], r[5:4], wd, r[12:11], 16'($urandom),
                (r[15:13] == 0) ? r[17:16] : 2'b00, "MIX");
        end
        report();
    end

    task automatic idle_cyc(string tag);
        cyc(0, 0, 0, 0, 8'h0, 2'b00, 16'h0, 2'b00, tag);
    endtask
endmodule